// File: doc/BRIEF.md
# DRAM Refresh Request Controller

This block decides when a DRAM refresh cycle should run and hands that decision to a RAS sequencer. Refresh requests come from two places. One is a periodic tick from an internal refresh timer. The other is an external request pin. A refresh-disable input selects which of the two is in charge. While refresh is disabled, timer ticks are ignored and the external pin requests refreshes. Holding that pin produces a burst of refreshes. While refresh is enabled, the timer drives refresh, and the same external pin has a different meaning: it resets the refresh row address counter to zero.

Once a request is accepted, the controller raises a busy flag. It waits until the sequencer reports RAS idle and no access is asking to hold refresh off. It then pulses a one-cycle start strobe. After that it follows the sequencer through one busy period and back to idle. The busy flag drops at the clock edge where the sequencer reports idle again. The row counter advances at that same edge. The counter value is presented as the row address for the next refresh.

Top module: `rfsh_ctl`

## Requirements
- R1: While `rfsh_off` is 1, a `tmr_tick` never causes a refresh. The busy flag only rises when `ext_rfsh` was 1 at the preceding edge. Any tick pending at the moment refresh is disabled is dropped.
- R2: With `rfsh_off` at 1 and the controller idle, a one-cycle pulse on `ext_rfsh` yields exactly one `rfsh_go` strobe.
- R3: With `rfsh_off` at 1 and `ext_rfsh` held at 1, refreshes run back to back. The busy flag rises again one cycle after it falls. Once `ext_rfsh` drops, at most the refresh already in flight completes and no further strobe follows.
- R4: A 1 on `ext_rfsh` while `rfsh_off` is 0 sets `rfsh_row` to 0 at that edge and starts no refresh. If it coincides with the completion of a refresh, the clear wins over the increment.
- R5: `rfsh_busy` is 1 in the cycle before every `rfsh_go` strobe. The strobe lasts one cycle.
- R6: `rfsh_busy` stays 1 after the strobe until `ras_idle` has gone to 0 and then returned to 1. It falls at the edge where `ras_idle` is seen at 1 again.
- R7: `rfsh_row` increases by one at each refresh completion, modulo 2^ROW_W (default 10 bits). After reset it is 0.
- R8: A timer tick while refresh is enabled stays pending until it is serviced. Further ticks while it is pending add no extra refresh. A tick that arrives at the same edge as the completion of the refresh that serviced the earlier one stays pending.
- R9: `rfsh_go` is issued only when, at the previous edge, `ras_idle` was 1 and `acc_hold` was 0. A refresh already requested waits as long as `acc_hold` stays 1 or `ras_idle` stays 0.
- R10: After reset, `rfsh_busy`, `rfsh_go` and `rfsh_row` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_rfsh | input | 1 | External refresh request / counter clear |
| rfsh_off | input | 1 | 1 disables timer-driven refresh |
| tmr_tick | input | 1 | One-cycle tick from the refresh timer |
| ras_idle | input | 1 | 1 when the RAS sequencer is idle |
| acc_hold | input | 1 | 1 while a pending access holds refresh off |
| rfsh_go | output | 1 | One-cycle strobe that starts a refresh cycle |
| rfsh_row | output | ROW_W | Refresh row address |
| rfsh_busy | output | 1 | Refresh in progress |

## Verification
Two functions can fall in the same cycle. One is the completion of a refresh, which increments the row counter. The other is an external request with refresh enabled, which clears it. The random phase toggles `rfsh_off` and pulses `ext_rfsh` while refreshes are completing, so the two do collide. At every cycle the bench compares `rfsh_row` against its own row model, in which a clear overrides an increment at the same edge. A second collision is a timer tick that arrives while an earlier tick is still waiting. A directed case holds the sequencer busy across two ticks and expects a single strobe.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        RF_IDLE   = 3'd0,
        RF_ARM    = 3'd1,
        RF_LAUNCH = 3'd2,
        RF_ACK    = 3'd3,
        RF_DRAIN  = 3'd4
    } rf_state_t;

    typedef struct packed {
        logic want;
        logic from_timer;
    } rf_req_t;

    function automatic rf_req_t pick_source(input logic off, input logic ext, input logic pend);
        rf_req_t r;
        r.from_timer = !off;
        r.want       = off ? ext : pend;
        return r;
    endfunction

endpackage

// File: rtl/rfsh_tick_pend.sv
module rfsh_tick_pend (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic int_off,
    input  logic serviced,
    output logic pend
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= !int_off && (tick || (pend_q && !serviced));
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
    import rfsh_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rf_req_t req,
    input  logic    ras_idle,
    input  logic    acc_hold,
    output logic    go,
    output logic    busy,
    output logic    done,
    output logic    done_timer
);
    rf_state_t st_q, st_d;
    logic      src_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RF_IDLE:   if (req.want) st_d = RF_ARM;
            RF_ARM:    if (ras_idle && !acc_hold) st_d = RF_LAUNCH;
            RF_LAUNCH: st_d = RF_ACK;
            RF_ACK:    if (!ras_idle) st_d = RF_DRAIN;
            RF_DRAIN:  if (ras_idle) st_d = RF_IDLE;
            default:   st_d = RF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RF_IDLE;
            src_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == RF_IDLE && req.want) begin
                src_q <= req.from_timer;
            end
        end
    end

    assign go         = (st_q == RF_LAUNCH);
    assign busy       = (st_q != RF_IDLE);
    assign done       = (st_q == RF_DRAIN) && ras_idle;
    assign done_timer = done && src_q;
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] ONE = ROW_W'(1);
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            row_q <= '0;
        end else if (inc) begin
            row_q <= row_q + ONE;
        end
    end

    assign row = row_q;
endmodule

// File: rtl/rfsh_ctl.sv
module rfsh_ctl
    import rfsh_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_rfsh,
    input  logic             rfsh_off,
    input  logic             tmr_tick,
    input  logic             ras_idle,
    input  logic             acc_hold,
    output logic             rfsh_go,
    output logic [ROW_W-1:0] rfsh_row,
    output logic             rfsh_busy
);
    logic    pend;
    logic    done;
    logic    done_timer;
    logic    row_clr;
    rf_req_t req;

    assign req     = pick_source(rfsh_off, ext_rfsh, pend);
    assign row_clr = ext_rfsh && !rfsh_off;

    rfsh_tick_pend pend_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tmr_tick),
        .int_off  (rfsh_off),
        .serviced (done_timer),
        .pend     (pend)
    );

    rfsh_seq_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .ras_idle   (ras_idle),
        .acc_hold   (acc_hold),
        .go         (rfsh_go),
        .busy       (rfsh_busy),
        .done       (done),
        .done_timer (done_timer)
    );

    rfsh_row_ctr #(.ROW_W(ROW_W)) ctr_i (
        .clk (clk),
        .rst (rst),
        .clr (row_clr),
        .inc (done),
        .row (rfsh_row)
    );
endmodule

// File: rtl/rfsh_ctl_chk.sv
module rfsh_ctl_chk #(
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_rfsh,
    input logic             rfsh_off,
    input logic             ras_idle,
    input logic             acc_hold,
    input logic             rfsh_go,
    input logic [ROW_W-1:0] rfsh_row,
    input logic             rfsh_busy
);
    // R5
    go_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rfsh_go |-> $past(rfsh_busy));

    // R5
    go_single_chk: assert property (@(posedge clk) disable iff (rst)
        rfsh_go |=> !rfsh_go);

    // R9
    go_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        rfsh_go |-> $past(ras_idle && !acc_hold));

    // R6
    busy_end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rfsh_busy) |-> $past(ras_idle));

    // R1
    off_ext_only_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rfsh_busy) && $past(rfsh_off)) |-> $past(ext_rfsh));

    // R4
    row_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ext_rfsh && !rfsh_off) |-> (rfsh_row == '0));

    // R7
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rfsh_busy) && !$past(ext_rfsh && !rfsh_off))
            |-> ((rfsh_row - $past(rfsh_row)) == ROW_W'(1)));
endmodule

bind rfsh_ctl rfsh_ctl_chk #(.ROW_W(ROW_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ext_rfsh  (ext_rfsh),
    .rfsh_off  (rfsh_off),
    .ras_idle  (ras_idle),
    .acc_hold  (acc_hold),
    .rfsh_go   (rfsh_go),
    .rfsh_row  (rfsh_row),
    .rfsh_busy (rfsh_busy)
);

// File: tb/rfsh_ctl_tb_top.sv
module rfsh_ctl_tb_top;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ext_rfsh = 1'b0;
    logic          rfsh_off = 1'b0;
    logic          tmr_tick = 1'b0;
    logic          ras_idle = 1'b1;
    logic          acc_hold = 1'b0;
    logic          rfsh_go;
    logic [AW-1:0] rfsh_row;
    logic          rfsh_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    // wanted stimulus
    bit want_ext = 0, want_off = 0, want_tick = 0, want_acc = 0, want_rst = 1;
    int frc = 0;        // forced busy cycles (accesses)
    int seq_cnt = 0;    // sequencer busy cycles after a strobe
    int busy_len = 2;
    // values applied at last edge
    bit cur_ext = 0, cur_off = 0, cur_idle = 1, cur_acc = 0, cur_rst = 1;
    bit prev_busy = 0;
    bit gap_due = 0;
    logic [AW-1:0] exp_row = '0;
    int n_go = 0;

    always #2.5 clk = ~clk;

    rfsh_ctl #(.ROW_W(AW)) dut_i (
        .clk(clk), .rst(rst), .ext_rfsh(ext_rfsh), .rfsh_off(rfsh_off),
        .tmr_tick(tmr_tick), .ras_idle(ras_idle), .acc_hold(acc_hold),
        .rfsh_go(rfsh_go), .rfsh_row(rfsh_row), .rfsh_busy(rfsh_busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        bit fell;
        @(negedge clk);
        fell = prev_busy && !rfsh_busy;
        if (cur_rst) begin
            exp_row = '0;
        end else begin
            if (cur_ext && !cur_off) exp_row = '0;
            else if (fell) exp_row = exp_row + AW'(1);
            chk(rfsh_row == exp_row, "R7 row value", int'(rfsh_row), int'(exp_row));
            if (gap_due) chk(rfsh_busy, "R3 back-to-back", int'(rfsh_busy), 1);
            if (rfsh_go) begin
                n_go++;
                chk(prev_busy, "R5 busy before go", int'(prev_busy), 1);
                chk(cur_idle && !cur_acc, "R9 go only when free", int'(cur_idle && !cur_acc), 1);
                seq_cnt = busy_len;
            end
            if (fell) chk(cur_idle, "R6 busy falls on idle", int'(cur_idle), 1);
            if (rfsh_busy && !prev_busy && cur_off)
                chk(cur_ext, "R1 only ext when off", int'(cur_ext), 1);
        end
        prev_busy = rfsh_busy;
        // drive
        if (seq_cnt > 0) begin ras_idle = 1'b0; seq_cnt--; end
        else if (frc > 0) begin ras_idle = 1'b0; frc--; end
        else ras_idle = 1'b1;
        rst = want_rst;
        ext_rfsh = want_ext;
        rfsh_off = want_off;
        tmr_tick = want_tick;
        want_tick = 0;
        acc_hold = want_acc;
        gap_due = fell && want_ext && want_off && !want_rst;
        cur_ext = want_ext; cur_off = want_off; cur_idle = ras_idle;
        cur_acc = want_acc; cur_rst = want_rst;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int g0;
        int g1;
        void'($urandom(32'h5eed_1234));
        run(4);
        // R10 reset state
        chk(rfsh_busy == 0 && rfsh_go == 0 && rfsh_row == 0, "R10 reset state",
            int'({rfsh_busy, rfsh_go, rfsh_row == 0}), 1);
        want_rst = 0;
        run(3);

        // R8: two ticks while sequencer held busy -> one refresh
        frc = 30;
        want_tick = 1; run(3);
        want_tick = 1; run(3);
        g0 = n_go;
        frc = 0;
        run(40);
        chk(n_go - g0 == 1, "R8 single service of pending tick", n_go - g0, 1);

        // R9: acc_hold keeps a requested refresh waiting
        want_acc = 1;
        want_tick = 1;
        g0 = n_go;
        run(25);
        chk(n_go == g0, "R9 hold-off by acc_hold", n_go - g0, 0);
        chk(rfsh_busy, "R5 busy while waiting", int'(rfsh_busy), 1);
        want_acc = 0;
        run(20);
        chk(n_go - g0 == 1, "R9 refresh after release", n_go - g0, 1);

        // R4: clear with refresh enabled, no refresh started
        chk(rfsh_row != 0, "R4 precondition row nonzero", int'(rfsh_row), 2);
        g0 = n_go;
        want_ext = 1; step(); want_ext = 0;
        step();
        chk(rfsh_row == 0, "R4 clear", int'(rfsh_row), 0);
        run(20);
        chk(n_go == g0, "R4 no refresh from clear", n_go - g0, 0);

        // R1: disabled, ticks ignored
        want_off = 1;
        run(2);
        g0 = n_go;
        for (int i = 0; i < 5; i++) begin want_tick = 1; run(4); end
        run(20);
        chk(n_go == g0, "R1 ticks suppressed", n_go - g0, 0);

        // R2: single pulse
        g0 = n_go;
        want_ext = 1; step(); want_ext = 0;
        run(25);
        chk(n_go - g0 == 1, "R2 one refresh per pulse", n_go - g0, 1);

        // R3 / R7: long burst across wrap
        busy_len = 2;
        want_ext = 1;
        g0 = n_go;
        run(5600);
        chk(n_go - g0 > 1024, "R3 burst count", n_go - g0, 1025);
        want_ext = 0;
        run(15);
        g1 = n_go;
        run(30);
        chk(n_go == g1, "R3 burst stops", n_go - g1, 0);
        chk(rfsh_row == exp_row, "R7 wrapped row", int'(rfsh_row), int'(exp_row));

        // random mix
        for (int i = 0; i < 4000; i++) begin
            want_tick = ($urandom_range(0, 15) == 0);
            want_acc  = ($urandom_range(0, 3) == 0);
            want_ext  = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 63) == 0) want_off = !want_off;
            busy_len = $urandom_range(2, 4);
            if (!rfsh_busy && seq_cnt == 0 && frc == 0 && $urandom_range(0, 7) == 0)
                frc = $urandom_range(1, 5);
            step();
        end
        want_ext = 0; want_acc = 0;
        run(20);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule